// File: doc/BRIEF.md
# Bipolar Line Encoder with Zero-Run Substitution

This block turns a serial binary stream into a three-level line code. One bit is taken on each clock where `bit_en` is high. A binary zero normally becomes the zero level. A binary one becomes a pulse whose polarity is opposite to the pulse sent before it. Exactly one of three one-hot outputs is high at a time: negative, zero or positive.

A long stretch of zero levels would starve the receiver of timing edges. So every run of four input zeros is replaced by a four-slot pattern that ends in a deliberate polarity violation, meaning a pulse with the same sign as the previous pulse. A parity flag picks the pattern so that the line stays DC-balanced. The flag records whether an odd or even number of data pulses has gone out since the last substitution:
- Even count: the pattern is a balancing pulse, two zeros, then the violation.
- Odd count: the pattern is three zeros, then the violation.

To spot a run before its first slot is emitted, the input passes through a three-stage delay line. Each symbol therefore describes the bit accepted three enables earlier. The output register adds one clock edge on top of that.

Top module: `bipolar_zs_encoder`

## Requirements
- R1: While `rst` is high, and after reset until three enabled bits have been accepted, the output is the zero level (`lvl_zero`=1, `lvl_neg`=`lvl_pos`=0).
- R2: In every cycle exactly one of `lvl_neg`, `lvl_zero` and `lvl_pos` is 1.
- R3: The symbol presented after the k-th enabled bit (counting from 0) encodes bit k-3. While `bit_en` is low, the outputs and all internal state hold.
- R4: Outside a substitution, a binary zero gives the zero level and a binary one gives a pulse opposite in sign to the most recent nonzero output. After reset the most recent polarity is taken as negative, so the first data pulse is positive.
- R5: When four consecutive input bits are zero, their four slots are replaced. With an even data-pulse count the slots become a pulse opposite to the last one, zero, zero, violation. The pulse that leads this pattern also updates the polarity.
- R6: The violation pulse in the last slot of a substitution has the same sign as the nonzero output just before it.
- R7: The parity flag toggles on each data pulse and is cleared by each violation. With an odd count the four slots become zero, zero, zero, violation. After a substitution the count is even.
- R8: Take the running sum of emitted levels (+1, 0, -1), starting at -1 at reset to match the reset polarity. This sum stays between -1 and +1.
- R9: Once real data reaches the output, four consecutive enabled symbols are never all zero level.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| bit_en | input | 1 | Accept `bit_in` and advance the encoder on this edge |
| bit_in | input | 1 | Serial binary data |
| lvl_neg | output | 1 | Negative line level |
| lvl_zero | output | 1 | Zero line level |
| lvl_pos | output | 1 | Positive line level |

## Verification
The embedded properties assume that `rst` and `bit_en` are clean and free of X, and that reset is released only on a clock edge. They also assume that the outputs change only on the edge after an enabled cycle, because the polarity and zero-run checkers watch the outputs rather than the internal state. The bench drives inputs only on falling edges and resets before every sequence. It sweeps all 1024 ten-bit patterns, so every placement of a zero run against every parity state is covered. A long pseudo-random stream with random gaps in `bit_en` then exercises the hold behaviour across substitutions.

// File: rtl/lenc_pkg.sv
package lenc_pkg;

  typedef enum logic [1:0] {
    SLOT_SPACE = 2'd0,
    SLOT_MARK  = 2'd1,
    SLOT_BAL   = 2'd2,
    SLOT_VIOL  = 2'd3
  } slot_kind_t;

  typedef struct packed {
    logic neg;
    logic zer;
    logic pos;
  } level_t;

  localparam level_t LEVEL_Z = '{neg: 1'b0, zer: 1'b1, pos: 1'b0};

  function automatic level_t mark_level(input logic positive);
    level_t l;
    l.neg = ~positive;
    l.zer = 1'b0;
    l.pos = positive;
    return l;
  endfunction

  function automatic level_t level_for(input slot_kind_t k, input logic last_pos);
    case (k)
      SLOT_SPACE: return LEVEL_Z;
      SLOT_VIOL:  return mark_level(last_pos);
      default:    return mark_level(~last_pos);
    endcase
  endfunction

  function automatic logic polarity_after(input slot_kind_t k, input logic last_pos);
    case (k)
      SLOT_MARK, SLOT_BAL: return ~last_pos;
      default:             return last_pos;
    endcase
  endfunction

  function automatic logic parity_after(input slot_kind_t k, input logic par_odd);
    case (k)
      SLOT_MARK: return ~par_odd;
      SLOT_VIOL: return 1'b0;
      default:   return par_odd;
    endcase
  endfunction

  function automatic logic signed [1:0] level_value(input level_t l);
    if (l.pos) return 2'sd1;
    if (l.neg) return -2'sd1;
    return 2'sd0;
  endfunction

endpackage

// File: rtl/lenc_delay.sv
module lenc_delay #(
  parameter int STAGES = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic din,
  output logic oldest,
  output logic run_hit,
  output logic filled
);
  localparam int FW = $clog2(STAGES + 1);

  logic [STAGES-1:0] taps_q;
  logic [FW-1:0]     fill_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      taps_q <= '0;
      fill_q <= '0;
    end else if (en) begin
      taps_q <= {taps_q[STAGES-2:0], din};
      if (fill_q != FW'(STAGES)) fill_q <= fill_q + 1'b1;
    end
  end

  assign oldest  = taps_q[STAGES-1];
  assign filled  = (fill_q == FW'(STAGES));
  assign run_hit = ~din & ~(|taps_q);

  // once the line holds real data it stays that way until reset
  assert_fill_sticky_R1: assert property (@(posedge clk) disable iff (rst)
    filled |=> filled);

endmodule

// File: rtl/lenc_seq.sv
module lenc_seq import lenc_pkg::*; #(
  parameter int RUN_LEN = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       en,
  input  logic       filled,
  input  logic       run_hit,
  input  logic       oldest,
  input  logic       par_odd,
  output slot_kind_t kind,
  output logic       sub_start
);
  localparam int CW = $clog2(RUN_LEN);

  logic [CW-1:0] left_q;

  always_comb begin
    kind      = SLOT_SPACE;
    sub_start = 1'b0;
    if (filled) begin
      if (left_q == '0) begin
        if (run_hit) begin
          sub_start = 1'b1;
          kind      = par_odd ? SLOT_SPACE : SLOT_BAL;
        end else begin
          kind = oldest ? SLOT_MARK : SLOT_SPACE;
        end
      end else if (left_q == CW'(1)) begin
        kind = SLOT_VIOL;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      left_q <= '0;
    end else if (en) begin
      if (left_q != '0)   left_q <= left_q - 1'b1;
      else if (sub_start) left_q <= CW'(RUN_LEN - 1);
    end
  end

  // a started substitution always ends in a violation slot
  assert_sub_ends_viol_R5: assert property (@(posedge clk) disable iff (rst)
    (en && left_q == CW'(1)) |-> (kind == SLOT_VIOL));

endmodule

// File: rtl/lenc_state.sv
module lenc_state import lenc_pkg::*; (
  input  logic       clk,
  input  logic       rst,
  input  logic       en,
  input  slot_kind_t kind,
  input  logic       slot_real,
  output logic       par_odd,
  output logic       last_pos,
  output level_t     sym,
  output logic       sym_real
);

  always_ff @(posedge clk) begin
    if (rst) begin
      par_odd  <= 1'b0;
      last_pos <= 1'b0;
      sym      <= LEVEL_Z;
      sym_real <= 1'b0;
    end else if (en) begin
      par_odd  <= parity_after(kind, par_odd);
      last_pos <= polarity_after(kind, last_pos);
      sym      <= level_for(kind, last_pos);
      sym_real <= slot_real;
    end
  end

  assert_prefill_zero_R1: assert property (@(posedge clk) disable iff (rst)
    !sym_real |-> (sym == LEVEL_Z));

  assert_onehot_R2: assert property (@(posedge clk) disable iff (rst)
    $countones(sym) == 1);

  assert_hold_R3: assert property (@(posedge clk) disable iff (rst)
    !en |=> ($stable(sym) && $stable(par_odd) && $stable(last_pos)));

  assert_parity_clear_R7: assert property (@(posedge clk) disable iff (rst)
    (en && kind == SLOT_VIOL) |=> !par_odd);

endmodule

// File: rtl/bipolar_zs_encoder.sv
module bipolar_zs_encoder import lenc_pkg::*; #(
  parameter int DELAY_STAGES = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic bit_en,
  input  logic bit_in,
  output logic lvl_neg,
  output logic lvl_zero,
  output logic lvl_pos
);
  localparam int RUN_LEN = DELAY_STAGES + 1;

  logic       oldest, run_hit, filled;
  logic       par_odd, last_pos, sym_real, sub_start;
  slot_kind_t kind;
  level_t     sym;

  lenc_delay #(.STAGES(DELAY_STAGES)) delay_i (
    .clk(clk), .rst(rst), .en(bit_en), .din(bit_in),
    .oldest(oldest), .run_hit(run_hit), .filled(filled)
  );

  lenc_seq #(.RUN_LEN(RUN_LEN)) seq_i (
    .clk(clk), .rst(rst), .en(bit_en), .filled(filled),
    .run_hit(run_hit), .oldest(oldest), .par_odd(par_odd),
    .kind(kind), .sub_start(sub_start)
  );

  lenc_state state_i (
    .clk(clk), .rst(rst), .en(bit_en), .kind(kind), .slot_real(filled),
    .par_odd(par_odd), .last_pos(last_pos), .sym(sym), .sym_real(sym_real)
  );

  assign lvl_neg  = sym.neg;
  assign lvl_zero = sym.zer;
  assign lvl_pos  = sym.pos;

  // checkers that watch the outputs only
  logic              en_d;
  logic              chk_last_pos;
  logic signed [2:0] chk_sum;
  logic [3:0]        chk_zrun;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_d         <= 1'b0;
      chk_last_pos <= 1'b0;
      chk_sum      <= -3'sd1;
      chk_zrun     <= '0;
    end else begin
      en_d <= bit_en;
      if (lvl_pos)      chk_last_pos <= 1'b1;
      else if (lvl_neg) chk_last_pos <= 1'b0;
      if (en_d) begin
        chk_sum <= chk_sum + {level_value(sym)[1], level_value(sym)};
        if (sym_real && lvl_zero) chk_zrun <= (chk_zrun == 4'd15) ? chk_zrun : chk_zrun + 1'b1;
        else                      chk_zrun <= '0;
      end
    end
  end

  assert_mark_alternates_R4: assert property (@(posedge clk) disable iff (rst)
    (bit_en && kind == SLOT_MARK) |=> (!lvl_zero && (lvl_pos != chk_last_pos)));

  assert_balance_pulse_R5: assert property (@(posedge clk) disable iff (rst)
    (bit_en && sub_start && !par_odd) |=> (!lvl_zero && (lvl_pos != chk_last_pos)));

  assert_viol_same_sign_R6: assert property (@(posedge clk) disable iff (rst)
    (bit_en && kind == SLOT_VIOL) |=> (!lvl_zero && (lvl_pos == chk_last_pos)));

  assert_sum_bounded_R8: assert property (@(posedge clk) disable iff (rst)
    (chk_sum >= -3'sd1) && (chk_sum <= 3'sd1));

  assert_zero_run_R9: assert property (@(posedge clk) disable iff (rst)
    chk_zrun <= 4'(RUN_LEN - 1));

endmodule

// File: tb/bipolar_zs_encoder_tb_top.sv
`timescale 1ns/1ps
module bipolar_zs_encoder_tb_top;
  localparam int MAXN  = 4096;
  localparam int LIMIT = 190000;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst, bit_en, bit_in;
  wire  lvl_neg, lvl_zero, lvl_pos;

  bipolar_zs_encoder dut_i (
    .clk(clk), .rst(rst), .bit_en(bit_en), .bit_in(bit_in),
    .lvl_neg(lvl_neg), .lvl_zero(lvl_zero), .lvl_pos(lvl_pos)
  );

  int n_checks = 0;
  int n_fail   = 0;
  int cyc      = 0;
  bit done     = 0;
  int xs [MAXN];
  int ex [MAXN];
  int tg [MAXN];
  int lfsr = 16'hACE1;

  task automatic check(input bit ok, input string req, input int act, input int expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  function automatic int out_val();
    if (lvl_pos) return 1;
    if (lvl_neg) return -1;
    return 0;
  endfunction

  task automatic get_rand(output int r);
    for (int b = 0; b < 8; b++) begin
      lfsr = (lfsr & 1) ? ((lfsr >> 1) ^ 16'hB400) : (lfsr >> 1);
    end
    r = lfsr;
  endtask

  function automatic string tag_name(input int c);
    case (c)
      4: return "R4";
      5: return "R5";
      6: return "R6";
      default: return "R7";
    endcase
  endfunction

  // look-ahead reference: groups zero runs from the future directly
  task automatic build_ref(input int n);
    int last = -1;
    int par  = 0;
    int i    = 0;
    while (i <= n - 4) begin
      if (xs[i] == 0 && xs[i+1] == 0 && xs[i+2] == 0 && xs[i+3] == 0) begin
        if (par == 0) begin last = -last; ex[i] = last; tg[i] = 5; end
        else begin ex[i] = 0; tg[i] = 7; end
        ex[i+1] = 0; tg[i+1] = 5;
        ex[i+2] = 0; tg[i+2] = 5;
        ex[i+3] = last; tg[i+3] = 6;
        par = 0;
        i += 4;
      end else begin
        if (xs[i] != 0) begin last = -last; ex[i] = last; par ^= 1; end
        else ex[i] = 0;
        tg[i] = 4;
        i++;
      end
    end
  endtask

  task automatic do_reset();
    rst = 1'b1; bit_en = 1'b0; bit_in = 1'b0;
    repeat (2) @(negedge clk);
    check(lvl_zero && !lvl_neg && !lvl_pos, "R1 reset level", out_val(), 0);
    rst = 1'b0;
  endtask

  task automatic run_seq(input int n, input bit gaps);
    int sum = -1;
    int zr  = 0;
    int r, v, expv, prev;
    do_reset();
    build_ref(n);
    for (int j = 0; j < n; j++) begin
      if (gaps) begin
        get_rand(r);
        for (int g = 0; g < (r % 3); g++) begin
          bit_en = 1'b0;
          bit_in = r[4];
          prev = out_val();
          @(negedge clk);
          check(out_val() == prev, "R3 hold while disabled", out_val(), prev);
        end
      end
      bit_en = 1'b1;
      bit_in = xs[j][0];
      @(negedge clk);
      v = out_val();
      check((lvl_neg + lvl_zero + lvl_pos) == 1, "R2 one-hot",
            lvl_neg + lvl_zero + lvl_pos, 1);
      if (j < 3) begin
        check(v == 0, "R1 prefill zero", v, 0);
      end else begin
        expv = ex[j-3];
        check(v == expv, tag_name(tg[j-3]), v, expv);
        zr = (v == 0) ? zr + 1 : 0;
        check(zr <= 3, "R9 zero run", zr, 3);
      end
      sum += v;
      check(sum >= -1 && sum <= 1, "R8 running sum", sum, 0);
    end
    bit_en = 1'b0;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > LIMIT && !done) begin
      done = 1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog (all requirements): actual cycles %0d expected below %0d", cyc, LIMIT);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    int r;
    rst = 1'b1; bit_en = 1'b0; bit_in = 1'b0;
    // exhaustive ten-bit patterns: every run position and parity (R3..R7)
    for (int p = 0; p < 1024; p++) begin
      for (int i = 0; i < 10; i++) xs[i] = (p >> i) & 1;
      run_seq(10, 1'b0);
    end
    // long zero stream: back-to-back substitutions (R5, R6)
    for (int i = 0; i < 40; i++) xs[i] = 0;
    run_seq(40, 1'b0);
    // all ones: pure alternation (R4)
    for (int i = 0; i < 24; i++) xs[i] = 1;
    run_seq(24, 1'b0);
    // pseudo-random stream biased toward zeros, with enable gaps (R3, R8, R9)
    for (int i = 0; i < 3000; i++) begin
      get_rand(r);
      xs[i] = ((r & 3) == 0) ? 1 : 0;
    end
    run_seq(3000, 1'b1);
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

endmodule